// File: doc/BRIEF.md
# Nested-Loop Transfer Address Generator

This block walks the address pattern of one transfer request that has up to four nested loops. The innermost loop covers a run of contiguous bytes, one address per byte. Each outer loop moves the starting point of the loop inside it by a signed stride. The request type picks how many loops are active: type 0 has one, type 1 has two, type 2 has three and type 3 has four. Addresses leave on a valid/ready stream. The loop counters move only when a beat is taken, so a slow consumer just stretches the walk.

The walk can be paced by an external trigger. A 2-bit select picks the trigger source, and a 2-bit code sets how much of the walk one trigger releases. An event pulse can be raised at a chosen loop level. A completion pulse closes every request and carries a status code and the request's command tag. A request that is malformed never starts: it gets an error status at once.

Top module: `tr_addr_gen`

## Requirements
- R1: The beat with loop indices i3,i2,i1,i0 carries address base + i0 + i1*stride1 + i2*stride2 + i3*stride3, modulo 2^ADDR_W. Strides are two's complement. i0 runs from 0 to count0-1 and is the fastest index, then i1, then i2, then i3. Loops above the request type run once. An active outer count of zero is also treated as one.
- R2: The counters advance only on a cycle with addr_valid and addr_ready both high and abort low. While addr_valid is high and addr_ready is low, addr_valid stays high and addr holds its value into the next cycle.
- R3: After reset, busy, addr_valid, evt and done are low. With trigger select 0 and addr_ready held high, the first address is valid the cycle after start is sampled. One beat is then accepted per cycle, and done pulses the cycle after the last beat is accepted.
- R4: With event size 0, evt pulses exactly once per request, in the same cycle as the completion done.
- R5: With event size L (1 to 3) and L not above the request type, evt pulses once each time the loops 0 to L-1 all finish on an accepted beat. That is once per step of loop L, including its final step.
- R6: With event size L above the request type, evt pulses exactly once, on the final beat.
- R7: Trigger select codes are 0 for none, 1 for glb_trig[0], 2 for glb_trig[1] and 3 for loc_evt. With a nonzero select, no address is offered until a trigger is seen. Each trigger then releases one unit of the walk: with trigger code 0 a unit is one pass of loop 0, with code 1 one pass of loops 0-1, with code 2 one pass of loops 0-2, and with code 3 the whole request.
- R8: A trigger that arrives while no unit is being waited for is held, and it opens the next unit without a further trigger. The held trigger is kept even while idle, and only one is stored.
- R9: A request with a supported type and count0 of zero is rejected. The cycle after start, done pulses with resp_status 3 and resp_info 0, and no address is issued.
- R10: A request type above 3 is rejected. The cycle after start, done pulses with resp_status 4 and resp_info 0. This check takes priority over R9.
- R11: Normal completion reports resp_status 0. Abort during a walk ends it: the cycle after abort is seen, done pulses with resp_status 2 and no further address is issued. Every done carries the request's cmd_id on resp_cmd.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Submit a request (sampled when idle) |
| abort | input | 1 | Stop the current walk |
| tr_type | input | 4 | Request type, 0 to 3 supported |
| base_addr | input | ADDR_W | Start address |
| icnt0 | input | CNT_W | Innermost byte count |
| icnt1 | input | CNT_W | Loop 1 count |
| icnt2 | input | CNT_W | Loop 2 count |
| icnt3 | input | CNT_W | Loop 3 count |
| dim1 | input | DIM_W | Signed stride of loop 1 |
| dim2 | input | DIM_W | Signed stride of loop 2 |
| dim3 | input | DIM_W | Signed stride of loop 3 |
| evt_size | input | 2 | Event loop level (0 = completion) |
| trig_sel | input | 2 | Trigger source select |
| trig_type | input | 2 | Walk released per trigger |
| cmd_id | input | CMD_W | Request tag returned on completion |
| glb_trig | input | 2 | Global trigger pulses 0 and 1 |
| loc_evt | input | 1 | Local event trigger pulse |
| busy | output | 1 | A walk is in progress |
| addr_valid | output | 1 | addr holds a beat |
| addr_ready | input | 1 | Consumer takes the beat |
| addr | output | ADDR_W | Byte address |
| evt | output | 1 | Event pulse |
| done | output | 1 | Completion pulse |
| resp_status | output | 4 | Status type of the finished request |
| resp_info | output | 4 | Status detail (0 for all codes used) |
| resp_cmd | output | CMD_W | Tag of the finished request |

## Verification
Every registered result appears one clock after the edge that causes it. addr_valid rises the cycle after start, or the cycle after a trigger that opens a unit. evt and done rise the cycle after the beat that earns them, and a rejection or abort answers the cycle after start or abort is sampled. The bench drives inputs and reads outputs only on the falling edge. At each falling edge it first takes in the registered results of the edge just passed, and only then sets up the next ready value and judges the beat the coming edge will accept. The free-running case is timed exactly: done must appear in observation count+1. For paced runs, the bench counts the beats between its own triggers.

// File: rtl/tr_addr_pkg.sv
package tr_addr_pkg;
   localparam int NLVL = 4;

   typedef enum logic [3:0] {
      RS_OK     = 4'd0,
      RS_XFER   = 4'd1,
      RS_ABORT  = 4'd2,
      RS_SUBMIT = 4'd3,
      RS_UNSUP  = 4'd4
   } resp_e;

   typedef enum logic [1:0] {
      TSRC_NONE  = 2'd0,
      TSRC_G0    = 2'd1,
      TSRC_G1    = 2'd2,
      TSRC_LOCAL = 2'd3
   } tsrc_e;
endpackage

// File: rtl/tr_req_check.sv
module tr_req_check
   import tr_addr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [3:0]       tr_type,
   input  logic [CNT_W-1:0] cnt0,
   output logic             reject,
   output resp_e            code
);
   always_comb begin
      reject = 1'b1;
      code   = RS_OK;
      if (tr_type > 4'd3)
         code = RS_UNSUP;
      else if (cnt0 == '0)
         code = RS_SUBMIT;
      else
         reject = 1'b0;
   end
endmodule

// File: rtl/tr_loop_walk.sv
module tr_loop_walk
   import tr_addr_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 16,
   parameter int DIM_W  = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [ADDR_W-1:0]           base,
   input  logic [NLVL-1:0][CNT_W-1:0]  n_in,
   input  logic [NLVL-1:1][DIM_W-1:0]  dim_in,
   input  logic                        step,
   output logic [ADDR_W-1:0]           addr,
   output logic [NLVL-1:0]             upto
);
   logic [NLVL-1:0][CNT_W-1:0]  n_q;
   logic [NLVL-1:0][CNT_W-1:0]  c_q;
   logic [NLVL-1:1][DIM_W-1:0]  d_q;
   logic [NLVL-1:1][ADDR_W-1:0] b_q;
   logic [NLVL-1:1][ADDR_W-1:0] sum;
   logic [NLVL-1:0]             last;
   logic [NLVL-1:0]             carry;
   logic                        adv_ok;
   int                          adv_lvl;

   // per-level end detection and carry chain
   always_comb begin
      for (int k = 0; k < NLVL; k++)
         last[k] = (c_q[k] == n_q[k] - CNT_W'(1));
      carry[0] = 1'b1;
      upto[0]  = last[0];
      for (int k = 1; k < NLVL; k++) begin
         carry[k] = upto[k-1];
         upto[k]  = upto[k-1] & last[k];
      end
   end

   // the single level that steps forward on this beat
   always_comb begin
      adv_ok  = 1'b0;
      adv_lvl = 0;
      for (int k = 0; k < NLVL; k++) begin
         if (!adv_ok && carry[k] && !last[k]) begin
            adv_ok  = 1'b1;
            adv_lvl = k;
         end
      end
   end

   generate
      for (genvar k = 1; k < NLVL; k++) begin : g_sum
         assign sum[k] = b_q[k] + ADDR_W'($signed(d_q[k]));
      end
   endgenerate

   assign addr = b_q[1] + ADDR_W'(c_q[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= '0;
         c_q <= '0;
         d_q <= '0;
         b_q <= '0;
      end else if (load) begin
         n_q <= n_in;
         d_q <= dim_in;
         c_q <= '0;
         for (int j = 1; j < NLVL; j++)
            b_q[j] <= base;
      end else if (step) begin
         for (int k = 0; k < NLVL; k++)
            if (carry[k])
               c_q[k] <= last[k] ? '0 : c_q[k] + CNT_W'(1);
         for (int j = 1; j < NLVL; j++)
            if (adv_ok && j <= adv_lvl)
               b_q[j] <= sum[adv_lvl];
      end
   end

   // R1
   innermost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (c_q[0] < n_q[0]));
endmodule

// File: rtl/tr_trig_gate.sv
module tr_trig_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic load,
   input  logic gated,
   input  logic hit,
   input  logic unit_end,
   output logic open
);
   logic pend_q;
   logic unit_q;
   logic take;

   assign take = run && gated && !unit_q && (pend_q || hit) && !load;
   assign open = !gated || unit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         unit_q <= 1'b0;
      end else if (take) begin
         unit_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         if (hit)
            pend_q <= 1'b1;
         if (load || unit_end)
            unit_q <= 1'b0;
      end
   end

   // R7
   unit_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unit_q) |-> $past(pend_q || hit));

   // R7
   unit_close_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unit_q) |-> $past(unit_end || load));
endmodule

// File: rtl/tr_addr_gen.sv
module tr_addr_gen
   import tr_addr_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 16,
   parameter int DIM_W  = 32,
   parameter int CMD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [3:0]        tr_type,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [CNT_W-1:0]  icnt0,
   input  logic [CNT_W-1:0]  icnt1,
   input  logic [CNT_W-1:0]  icnt2,
   input  logic [CNT_W-1:0]  icnt3,
   input  logic [DIM_W-1:0]  dim1,
   input  logic [DIM_W-1:0]  dim2,
   input  logic [DIM_W-1:0]  dim3,
   input  logic [1:0]        evt_size,
   input  logic [1:0]        trig_sel,
   input  logic [1:0]        trig_type,
   input  logic [CMD_W-1:0]  cmd_id,
   input  logic [1:0]        glb_trig,
   input  logic              loc_evt,
   output logic              busy,
   output logic              addr_valid,
   input  logic              addr_ready,
   output logic [ADDR_W-1:0] addr,
   output logic              evt,
   output logic              done,
   output logic [3:0]        resp_status,
   output logic [3:0]        resp_info,
   output logic [CMD_W-1:0]  resp_cmd
);
   localparam logic [3:0] INFO_NONE = 4'd0;

   generate
      if (ADDR_W < DIM_W) begin : g_bad_addr
         $error("ADDR_W must be at least DIM_W");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (CMD_W < 1) begin : g_bad_cmd
         $error("CMD_W must be at least 1");
      end
   endgenerate

   logic [NLVL-1:0][CNT_W-1:0] icnt_arr;
   logic [NLVL-1:0][CNT_W-1:0] n_eff;
   logic [NLVL-1:1][DIM_W-1:0] dims;
   logic [NLVL-1:0]            upto;
   logic                       reject;
   resp_e                      rej_code;
   logic                       accept, load, step, fin, evt_hit, unit_end, hit, open;
   logic [1:0]                 esz_q, ttyp_q, sel_now;
   tsrc_e                      tsel_q;
   logic [CMD_W-1:0]           cmd_q;

   assign icnt_arr = {icnt3, icnt2, icnt1, icnt0};
   assign dims     = {dim3, dim2, dim1};

   // an outer loop outside the type, or with a zero count, runs once
   assign n_eff[0] = icnt0;
   generate
      for (genvar k = 1; k < NLVL; k++) begin : g_eff
         assign n_eff[k] = (tr_type >= 4'(k) && icnt_arr[k] != '0) ? icnt_arr[k] : CNT_W'(1);
      end
   endgenerate

   tr_req_check #(.CNT_W(CNT_W)) u_check (
      .tr_type (tr_type),
      .cnt0    (icnt0),
      .reject  (reject),
      .code    (rej_code)
   );

   assign accept = start && !busy;
   assign load   = accept && !reject;
   assign step   = addr_valid && addr_ready && !abort;
   assign fin    = upto[NLVL-1];

   tr_loop_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIM_W(DIM_W)) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .base   (base_addr),
      .n_in   (n_eff),
      .dim_in (dims),
      .step   (step),
      .addr   (addr),
      .upto   (upto)
   );

   assign sel_now = busy ? tsel_q : trig_sel;
   always_comb begin
      case (tsrc_e'(sel_now))
         TSRC_G0:    hit = glb_trig[0];
         TSRC_G1:    hit = glb_trig[1];
         TSRC_LOCAL: hit = loc_evt;
         default:    hit = 1'b0;
      endcase
   end

   always_comb begin
      case (esz_q)
         2'd1:    evt_hit = upto[0];
         2'd2:    evt_hit = upto[1];
         2'd3:    evt_hit = upto[2];
         default: evt_hit = 1'b0;
      endcase
   end

   assign unit_end = step && upto[ttyp_q];

   tr_trig_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .load     (load),
      .gated    (tsel_q != TSRC_NONE),
      .hit      (hit),
      .unit_end (unit_end),
      .open     (open)
   );

   assign addr_valid = busy && open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         evt         <= 1'b0;
         done        <= 1'b0;
         resp_status <= RS_OK;
         resp_info   <= INFO_NONE;
         resp_cmd    <= '0;
         esz_q       <= '0;
         ttyp_q      <= '0;
         tsel_q      <= TSRC_NONE;
         cmd_q       <= '0;
      end else begin
         evt  <= 1'b0;
         done <= 1'b0;
         if (accept) begin
            if (reject) begin
               done        <= 1'b1;
               resp_status <= rej_code;
               resp_info   <= INFO_NONE;
               resp_cmd    <= cmd_id;
            end else begin
               busy   <= 1'b1;
               esz_q  <= evt_size;
               ttyp_q <= trig_type;
               tsel_q <= tsrc_e'(trig_sel);
               cmd_q  <= cmd_id;
            end
         end else if (busy) begin
            if (abort) begin
               busy        <= 1'b0;
               done        <= 1'b1;
               resp_status <= RS_ABORT;
               resp_info   <= INFO_NONE;
               resp_cmd    <= cmd_q;
            end else if (step) begin
               if (evt_hit)
                  evt <= 1'b1;
               if (fin) begin
                  busy        <= 1'b0;
                  done        <= 1'b1;
                  resp_status <= RS_OK;
                  resp_info   <= INFO_NONE;
                  resp_cmd    <= cmd_q;
                  if (esz_q == 2'd0)
                     evt <= 1'b1;
               end
            end
         end
      end
   end

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !addr_ready && !abort) |=> (addr_valid && $stable(addr)));

   // R9
   zero_count_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && tr_type <= 4'd3 && icnt0 == '0) |=> (done && resp_status == 4'd3 && !busy));

   // R10
   bad_type_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && tr_type > 4'd3) |=> (done && resp_status == 4'd4 && !busy));

   // R11
   abort_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort) |=> (done && resp_status == 4'd2 && !busy && !addr_valid));

   // R11
   ok_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resp_status == 4'd0) |-> $past(addr_valid && addr_ready && !abort));

   // R5
   evt_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> $past(addr_valid && addr_ready && !abort));

   // R12
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !abort && !(addr_valid && addr_ready)) |=> busy);
endmodule

// File: tb/tb_tr_addr_gen.sv
module tb_tr_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 48;
   localparam longint AMASK = (64'd1 << ADDR_W) - 1;
   localparam longint BASE = 64'h0010_0000_0800;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0, abort = 1'b0;
   logic [3:0]        tr_type = '0;
   logic [ADDR_W-1:0] base_addr = '0;
   logic [15:0]       icnt0 = '0, icnt1 = '0, icnt2 = '0, icnt3 = '0;
   logic [31:0]       dim1 = '0, dim2 = '0, dim3 = '0;
   logic [1:0]        evt_size = '0, trig_sel = '0, trig_type = '0;
   logic [7:0]        cmd_id = '0;
   logic [1:0]        glb_trig = '0;
   logic              loc_evt = 1'b0;
   logic              busy, addr_valid, evt, done;
   logic              addr_ready = 1'b1;
   logic [ADDR_W-1:0] addr;
   logic [3:0]        resp_status, resp_info;
   logic [7:0]        resp_cmd;

   int errs = 0;
   int checks = 0;
   int run_no = 0;
   logic [7:0] lfsr = 8'hA5;

   tr_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .tr_type(tr_type),
      .base_addr(base_addr), .icnt0(icnt0), .icnt1(icnt1), .icnt2(icnt2), .icnt3(icnt3),
      .dim1(dim1), .dim2(dim2), .dim3(dim3), .evt_size(evt_size), .trig_sel(trig_sel),
      .trig_type(trig_type), .cmd_id(cmd_id), .glb_trig(glb_trig), .loc_evt(loc_evt),
      .busy(busy), .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
      .evt(evt), .done(done), .resp_status(resp_status), .resp_info(resp_info),
      .resp_cmd(resp_cmd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_line(input int sel, input bit v);
      glb_trig[0] = v && sel == 1;
      glb_trig[1] = v && sel == 2;
      loc_evt     = v && sel == 3;
   endtask

   task automatic run_req(input int ty, input int n0, input int n1, input int n2, input int n3,
                          input longint d1, input longint d2, input longint d3,
                          input int esz, input int tsel, input int ttyp, input int rmode,
                          input bit pre, input bit poke, input int abort_at);
      int e[4];
      longint total, unit, expa, evx;
      int i0, i1, i2, i3, beats, evts, iter, since, issued, idle_run;
      bit seen_done, first_trig, stalled, ab_done;
      logic [ADDR_W-1:0] stall_addr;
      logic [7:0] cmd;
      string er;
      e[0] = n0;
      e[1] = (ty >= 1 && n1 != 0) ? n1 : 1;
      e[2] = (ty >= 2 && n2 != 0) ? n2 : 1;
      e[3] = (ty >= 3 && n3 != 0) ? n3 : 1;
      total = longint'(e[0]) * e[1] * e[2] * e[3];
      unit = (ttyp == 0) ? e[0] : (ttyp == 1) ? e[0]*e[1] : (ttyp == 2) ? e[0]*e[1]*e[2] : total;
      run_no++;
      cmd = 8'(8'h30 + run_no);
      i0 = 0; i1 = 0; i2 = 0; i3 = 0; beats = 0; evts = 0; since = 0; issued = 0;
      idle_run = 0; seen_done = 0; first_trig = 1; stalled = 0; ab_done = 0; iter = 0;
      @(negedge clk);
      tr_type = 4'(ty); base_addr = ADDR_W'(BASE);
      icnt0 = 16'(n0); icnt1 = 16'(n1); icnt2 = 16'(n2); icnt3 = 16'(n3);
      dim1 = 32'(d1); dim2 = 32'(d2); dim3 = 32'(d3);
      evt_size = 2'(esz); trig_sel = 2'(tsel); trig_type = 2'(ttyp); cmd_id = cmd;
      if (pre) begin
         pulse_line(tsel, 1'b1);
         @(negedge clk);
         pulse_line(tsel, 1'b0);
      end
      start = 1'b1;
      addr_ready = 1'b1;
      for (int it = 1; it <= 3000; it++) begin
         @(negedge clk);
         iter = it;
         // R12: a second start while busy
         start = poke && it == 3;
         if (poke && it == 3) begin
            tr_type = 4'd7;
            icnt0 = '0;
         end
         pulse_line(tsel, 1'b0);
         abort = 1'b0;
         if (stalled) begin
            chk(addr_valid && addr == stall_addr, "R2", "stalled beat held",
                longint'(addr), longint'(stall_addr));
            stalled = 0;
         end
         if (evt) evts++;
         if (done) begin
            seen_done = 1;
            break;
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         addr_ready = (rmode == 0) ? 1'b1 : (lfsr[0] | lfsr[1]);
         if (abort_at > 0 && beats == abort_at && !ab_done) begin
            abort = 1'b1;
            ab_done = 1;
         end else if (addr_valid && addr_ready) begin
            expa = (BASE + i0 + i1*d1 + i2*d2 + i3*d3) & AMASK;
            chk(longint'(addr) == expa, "R1", "address", longint'(addr), expa);
            beats++;
            since++;
            i0++;
            if (i0 == e[0]) begin
               i0 = 0; i1++;
               if (i1 == e[1]) begin
                  i1 = 0; i2++;
                  if (i2 == e[2]) begin i2 = 0; i3++; end
               end
            end
         end else if (addr_valid) begin
            stalled = 1;
            stall_addr = addr;
         end
         if (tsel != 0 && busy && !addr_valid) idle_run++;
         else idle_run = 0;
         if (idle_run == 3) begin
            chk(since == ((first_trig && !pre) ? 0 : unit), "R7", "beats per trigger unit",
                longint'(since), (first_trig && !pre) ? 0 : unit);
            first_trig = 0;
            pulse_line(tsel, 1'b1);
            issued++;
            since = 0;
            idle_run = 0;
         end
      end
      chk(seen_done, "R11", "done seen", longint'(seen_done), 1);
      chk(resp_cmd == cmd, "R11", "command tag", longint'(resp_cmd), longint'(cmd));
      chk(resp_info == 4'd0, "R11", "status info", longint'(resp_info), 0);
      if (abort_at > 0) begin
         chk(resp_status == 4'd2, "R11", "abort status", longint'(resp_status), 2);
         chk(beats == abort_at, "R11", "beats before abort", longint'(beats), longint'(abort_at));
      end else begin
         chk(resp_status == 4'd0, "R11", "completion status", longint'(resp_status), 0);
         chk(beats == total, "R1", "beat count", longint'(beats), total);
         if (esz == 0) begin evx = 1; er = "R4"; end
         else if (esz > ty) begin evx = 1; er = "R6"; end
         else begin
            evx = 1;
            for (int k = esz; k < 4; k++) evx = evx * e[k];
            er = "R5";
         end
         chk(evts == evx, er, "event count", longint'(evts), evx);
         if (tsel == 0 && rmode == 0)
            chk(iter == total + 1, "R3", "free-run done cycle", longint'(iter), total + 1);
         if (tsel != 0)
            chk(issued == total / unit - (pre ? 1 : 0), pre ? "R8" : "R7", "triggers used",
                longint'(issued), total / unit - (pre ? 1 : 0));
      end
      @(negedge clk);
      chk(!addr_valid && !busy, "R11", "idle after done", longint'({busy, addr_valid}), 0);
   endtask

   task automatic run_reject(input int ty, input int n0, input int exp_st, input string req);
      logic [7:0] cmd;
      run_no++;
      cmd = 8'(8'h80 + run_no);
      @(negedge clk);
      tr_type = 4'(ty); icnt0 = 16'(n0); icnt1 = 16'd2; cmd_id = cmd; trig_sel = 2'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && resp_status == 4'(exp_st), req, "reject status",
          longint'({done, resp_status}), longint'({1'b1, 4'(exp_st)}));
      chk(resp_info == 4'd0 && resp_cmd == cmd && !busy && !addr_valid, req, "reject info/tag/idle",
          longint'({resp_info, resp_cmd}), longint'({4'd0, cmd}));
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errs++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      chk(!busy && !addr_valid && !evt && !done, "R3", "reset outputs",
          longint'({busy, addr_valid, evt, done}), 0);
      // R1 R4 R5 R6 sweep over type, event size and ready pattern
      for (int ty = 0; ty < 4; ty++)
         for (int es = 0; es < 4; es++)
            for (int rm = 0; rm < 2; rm++)
               run_req(ty, 3, 2, 2, 2, rm ? -64 : 100, rm ? 7 : -9, rm ? -1000 : 4096,
                       es, 0, 0, rm, 0, 0, 0);
      // R1 zero outer count and single-byte rows
      run_req(2, 2, 0, 3, 5, 16, -300, 9, 2, 0, 0, 1, 0, 0, 0);
      run_req(3, 1, 2, 2, 2, -1, -2, -4, 1, 0, 0, 0, 0, 0, 0);
      // R7 every trigger source and pacing code
      for (int ts = 1; ts < 4; ts++)
         for (int tt = 0; tt < 4; tt++)
            run_req(3, 2, 2, 2, 2, 8, -20, 64, 1, ts, tt, 0, 0, 0, 0);
      // R8 trigger held while idle
      run_req(2, 2, 2, 2, 1, 5, 50, 0, 2, 1, 1, 0, 1, 0, 0);
      run_req(1, 3, 2, 1, 1, 12, 0, 0, 0, 3, 0, 1, 1, 0, 0);
      // R12 start while busy
      run_req(1, 4, 3, 1, 1, -7, 0, 0, 1, 0, 0, 0, 0, 1, 0);
      // R11 abort mid walk
      run_req(3, 3, 3, 3, 3, 10, 100, 1000, 0, 0, 0, 0, 0, 0, 5);
      // R9 R10 rejections
      run_reject(5, 4, 4, "R10");
      run_reject(1, 0, 3, "R9");
      run_reject(7, 0, 4, "R10");
      run_reject(0, 0, 3, "R9");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule